// File: doc/BRIEF.md
# Availability-Limited Block Grant Arbiter

This block is the grant stage for one resource of a slotted scheduler, where a resource is one delay slot of one output fiber. In every iteration it takes a vector of requests from P input ports and grants a contiguous run of up to k of them. Here k is the number of places the resource still has free in the current slot. The scan that picks the winners starts at a stored pointer and walks upward or downward around the ring of ports. The grant vector is produced combinationally, so the same iteration cycle can use it.

Between slots the block keeps its own state. The scan direction reverses at every slot end. The pointer moves forward by one port at every second slot end, whatever the traffic was. The availability count takes the value handed over by the arbiter of the next-longer delay, or is refilled to full if this arbiter serves the longest delay. An accept strobe from the input side marks that one granted place has been taken, and lowers the count.

Several of these arbiters sit side by side, one per delay of a fiber, each built with a different initial pointer. Their availability outputs are chained into the shift-in inputs of their neighbours.

Top module: `blk_grant_arb`

## Requirements
- R1: Every granted port has its request bit set, and the number of grants equals the smaller of the availability count and the number of requests.
- R2: With the direction bit at 0 (upward), ports are scanned in the order ptr, ptr+1, ... modulo P. The first asserted requests met in that order are granted.
- R3: With the direction bit at 1 (downward), ports are scanned in the order ptr, ptr-1, ... modulo P, and the first asserted requests met are granted.
- R4: After reset the direction bit is 0. It inverts at each slot-end pulse and holds its value in every other cycle.
- R5: After reset the pointer equals parameter INIT_PTR. It advances by one modulo P at the 2nd, 4th, 6th... slot-end pulse after reset, whatever grants were issued, and holds in every other cycle.
- R6: After reset the availability output equals N_AV.
- R7: Each cycle with the accept strobe high and no slot-end pulse lowers availability by one, saturating at 0. At 0 no grants are issued.
- R8: On a slot-end pulse, availability loads shift_avail_i when IS_TOP is 0, and reloads N_AV when IS_TOP is 1. An accept strobe in the same cycle is ignored.
- R9: The grant vector follows the request vector in the same cycle, with no register in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | P | Request vector, one bit per input port |
| acc_i | input | 1 | Accept strobe: one granted place taken |
| slot_end_i | input | 1 | One-cycle pulse after the last iteration of a slot |
| shift_avail_i | input | $clog2(N_AV+1) | Availability handed over from the next-longer delay |
| grant_o | output | P | Grant vector, combinational |
| avail_o | output | $clog2(N_AV+1) | Current availability count |

## Verification
The checks assume that shift_avail_i never exceeds N_AV, since the neighbouring arbiter can never hold more than full availability. One property checks this input on every slot-end pulse. The stimulus hands over only values from 0 to N_AV. The checks also assume that accept strobes arrive only between slot ends, and a single collision case shows that an accept in the slot-end cycle is dropped. The direction and pointer checks rely on slot-end being a single-cycle pulse, so the bench always holds it high for exactly one clock.

// File: rtl/bga_pkg.sv
package bga_pkg;

    typedef enum logic {
        SCAN_UP   = 1'b0,
        SCAN_DOWN = 1'b1
    } scan_dir_e;

endpackage

// File: rtl/bga_scan.sv
module bga_scan
    import bga_pkg::*;
#(
    parameter int P  = 8,
    parameter int AW = 3,
    parameter int PW = 3
) (
    input  logic [P-1:0]  req_i,
    input  logic [PW-1:0] ptr_i,
    input  scan_dir_e     dir_i,
    input  logic [AW-1:0] avail_i,
    output logic [P-1:0]  grant_o
);

    // Ring walk from the pointer; the first avail_i requests met are granted.
    always_comb begin
        int taken;
        int idx;
        grant_o = '0;
        taken   = 0;
        for (int s = 0; s < P; s++) begin
            if (dir_i == SCAN_DOWN) begin
                idx = (int'(ptr_i) + P - s) % P;
            end else begin
                idx = (int'(ptr_i) + s) % P;
            end
            if (req_i[idx] && (taken < int'(avail_i))) begin
                grant_o[idx] = 1'b1;
                taken        = taken + 1;
            end
        end
    end

endmodule

// File: rtl/bga_state.sv
module bga_state
    import bga_pkg::*;
#(
    parameter int P        = 8,
    parameter int N_AV     = 4,
    parameter int AW       = 3,
    parameter int PW       = 3,
    parameter int INIT_PTR = 0,
    parameter bit IS_TOP   = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_i,
    input  logic          slot_end_i,
    input  logic [AW-1:0] shift_avail_i,
    output logic [PW-1:0] ptr_o,
    output scan_dir_e     dir_o,
    output logic [AW-1:0] avail_o
);

    typedef struct packed {
        logic [PW-1:0] ptr;
        scan_dir_e     dir;
        logic          odd_slot;
        logic [AW-1:0] avail;
    } arb_state_t;

    arb_state_t    st_d, st_q;
    logic [AW-1:0] reload_val;
    logic [PW-1:0] ptr_next;

    generate
        if (IS_TOP) begin : g_top_reload
            assign reload_val = AW'(N_AV);
        end else begin : g_chain_reload
            assign reload_val = shift_avail_i;
        end
    endgenerate

    assign ptr_next = (st_q.ptr == PW'(P - 1)) ? '0 : st_q.ptr + 1'b1;

    always_comb begin
        st_d = st_q;
        if (slot_end_i) begin
            st_d.avail    = reload_val;
            st_d.dir      = scan_dir_e'(~st_q.dir);
            st_d.odd_slot = ~st_q.odd_slot;
            if (st_q.odd_slot) begin
                st_d.ptr = ptr_next;
            end
        end else if (acc_i && (st_q.avail != '0)) begin
            st_d.avail = st_q.avail - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ptr      <= PW'(INIT_PTR);
            st_q.dir      <= SCAN_UP;
            st_q.odd_slot <= 1'b0;
            st_q.avail    <= AW'(N_AV);
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr_o   = st_q.ptr;
    assign dir_o   = st_q.dir;
    assign avail_o = st_q.avail;

endmodule

// File: rtl/blk_grant_arb.sv
module blk_grant_arb
    import bga_pkg::*;
#(
    parameter int P        = 8,
    parameter int N_AV     = 4,
    parameter int INIT_PTR = 2,
    parameter bit IS_TOP   = 1'b0,
    localparam int AW      = $clog2(N_AV + 1),
    localparam int PW      = (P > 1) ? $clog2(P) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [P-1:0]  req_i,
    input  logic          acc_i,
    input  logic          slot_end_i,
    input  logic [AW-1:0] shift_avail_i,
    output logic [P-1:0]  grant_o,
    output logic [AW-1:0] avail_o
);

    logic [PW-1:0] ptr_w;
    scan_dir_e     dir_w;

    bga_state #(
        .P        (P),
        .N_AV     (N_AV),
        .AW       (AW),
        .PW       (PW),
        .INIT_PTR (INIT_PTR),
        .IS_TOP   (IS_TOP)
    ) state_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .acc_i         (acc_i),
        .slot_end_i    (slot_end_i),
        .shift_avail_i (shift_avail_i),
        .ptr_o         (ptr_w),
        .dir_o         (dir_w),
        .avail_o       (avail_o)
    );

    bga_scan #(
        .P  (P),
        .AW (AW),
        .PW (PW)
    ) scan_i (
        .req_i   (req_i),
        .ptr_i   (ptr_w),
        .dir_i   (dir_w),
        .avail_i (avail_o),
        .grant_o (grant_o)
    );

    // R1
    grant_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o & ~req_i) == '0);

    // R1
    grant_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant_o) == (($countones(req_i) < int'(avail_o)) ?
                                $countones(req_i) : int'(avail_o)));

    // R7
    no_grant_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (avail_o == '0) |-> (grant_o == '0));

    // R7
    accept_decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i && !slot_end_i && avail_o != '0) |=> (avail_o == $past(avail_o) - 1'b1));

    // R4
    dir_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_end_i |=> (dir_w != $past(dir_w)));

    // R4
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_end_i |=> $stable(dir_w));

    // R5
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_end_i |=> $stable(ptr_w));

    // R8
    shift_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_end_i |-> (int'(shift_avail_i) <= N_AV));

    generate
        if (IS_TOP) begin : g_top_chk
            // R8
            reload_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
                slot_end_i |=> (int'(avail_o) == N_AV));
        end else begin : g_chain_chk
            // R8
            reload_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
                slot_end_i |=> (avail_o == $past(shift_avail_i)));
        end
    endgenerate

endmodule

// File: tb/blk_grant_arb_tb_top.sv
`timescale 1ns/1ps
module blk_grant_arb_tb_top;

    localparam int P    = 8;
    localparam int N_AV = 4;
    localparam int INIT = 2;
    localparam int AW   = $clog2(N_AV + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [P-1:0]  req = '0;
    logic          acc = 1'b0;
    logic          slot_end = 1'b0;
    logic [AW-1:0] shift_av = '0;
    logic [P-1:0]  grant, grant_top;
    logic [AW-1:0] avail, avail_top;

    int n_checks = 0;
    int n_fails  = 0;

    int m_ptr, m_dir, m_par, m_av, m_av_top;

    always #5 clk = ~clk;

    blk_grant_arb #(.P(P), .N_AV(N_AV), .INIT_PTR(INIT), .IS_TOP(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req), .acc_i(acc), .slot_end_i(slot_end),
        .shift_avail_i(shift_av), .grant_o(grant), .avail_o(avail));

    blk_grant_arb #(.P(P), .N_AV(N_AV), .INIT_PTR(INIT), .IS_TOP(1'b1)) dut_top_i (
        .clk(clk), .rst_n(rst_n), .req_i(req), .acc_i(acc), .slot_end_i(slot_end),
        .shift_avail_i(shift_av), .grant_o(grant_top), .avail_o(avail_top));

    function automatic logic [P-1:0] exp_grant(logic [P-1:0] r, int ptr, int dir, int av);
        logic [P-1:0] g = '0;
        int n = 0;
        for (int s = 0; s < P; s++) begin
            int idx = (dir != 0) ? (ptr + P - s) % P : (ptr + s) % P;
            if (r[idx] && n < av) begin
                g[idx] = 1'b1;
                n++;
            end
        end
        return g;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    // drive a request pattern and compare the grant in the same cycle (R9)
    task automatic check_req(string tag, logic [P-1:0] r);
        req = r;
        #1;
        check(tag, int'(grant), int'(exp_grant(r, m_ptr, m_dir, m_av)));
    endtask

    task automatic pulse_slot_end(int sh, bit with_acc);
        shift_av = AW'(sh);
        slot_end = 1'b1;
        acc      = with_acc;
        step();
        slot_end = 1'b0;
        acc      = 1'b0;
        m_av     = sh;
        m_av_top = N_AV;
        m_dir    = m_dir ^ 1;
        if (m_par != 0) m_ptr = (m_ptr + 1) % P;
        m_par    = m_par ^ 1;
    endtask

    task automatic pulse_accept();
        acc = 1'b1;
        step();
        acc = 1'b0;
        if (m_av > 0) m_av--;
        if (m_av_top > 0) m_av_top--;
    endtask

    task automatic t_reset();
        m_ptr = INIT; m_dir = 0; m_par = 0; m_av = N_AV; m_av_top = N_AV;
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        check("R6 avail after reset", int'(avail), N_AV);
        check("R6 top avail after reset", int'(avail_top), N_AV);
        req = '1;
        #1;
        // R2 R9: upward from pointer 2, four grants at ports 2..5
        check("R2 reset grant all-request", int'(grant), 8'h3C);
    endtask

    task automatic t_up_scan();
        req = 8'h83;
        #1;
        check("R1 sparse grant wraps", int'(grant), 8'h83);
        check_req("R1 no requests", 8'h00);
        check_req("R2 wrap pattern", 8'hC1);
        check_req("R2 alternate pattern", 8'h55);
        // R9: grant follows a request change with no clock edge in between
        req = 8'h10;
        #1;
        check("R9 same-cycle grant", int'(grant), 8'h10);
    endtask

    task automatic t_accept();
        pulse_accept();
        pulse_accept();
        check("R7 avail after two accepts", int'(avail), 2);
        req = '1;
        #1;
        check("R7 grant block of two", int'(grant), 8'h0C);
        repeat (3) pulse_accept();
        check("R7 avail saturates at 0", int'(avail), 0);
        req = '1;
        #1;
        check("R7 no grant at zero", int'(grant), 0);
    endtask

    task automatic t_slot_shift();
        pulse_slot_end(3, 1'b0);
        check("R8 avail loads shift-in", int'(avail), 3);
        check("R8 top reloads full", int'(avail_top), N_AV);
        req = '1;
        #1;
        // R3 R4 R5: downward from unchanged pointer 2: ports 2,1,0
        check("R3 downward after first slot end", int'(grant), 8'h07);
        repeat (3) step();
        req = '1;
        #1;
        check("R4 direction holds between slot ends", int'(grant), 8'h07);
        pulse_slot_end(4, 1'b0);
        req = '1;
        #1;
        // R5 R4: pointer 3, upward: ports 3..6
        check("R5 pointer step at second slot end", int'(grant), 8'h78);
        pulse_slot_end(1, 1'b1);
        check("R8 accept ignored at slot end", int'(avail), 1);
        check("R8 top ignores accept at slot end", int'(avail_top), N_AV);
        req = '1;
        #1;
        check("R3 single grant downward", int'(grant), 8'h08);
    endtask

    task automatic t_ptr_wrap();
        for (int k = 0; k < 14; k++) begin
            pulse_slot_end(k % (N_AV + 1), 1'b0);
            check_req("R5 pointer schedule all requests", '1);
            check_req("R3 pointer schedule sparse", 8'hA5);
        end
        // R5: grants do not affect the schedule; none issued at zero availability here
        pulse_slot_end(0, 1'b0);
        check_req("R5 zero avail slot", '1);
        pulse_slot_end(N_AV, 1'b0);
        check_req("R5 schedule after idle slot", 8'h3C);
    endtask

    initial begin
        #2;
        t_reset();
        t_up_scan();
        t_accept();
        t_slot_shift();
        t_ptr_wrap();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #2000000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule